// File: doc/BRIEF.md
# Prioritized Boot Source Sequencer

This block is the control sequencer that runs once after reset to decide which external device supplies the boot image. It first spends a fixed number of cycles in a trim-setup phase. It then tries four storage devices, one at a time and always in the same order. Each attempt is a start pulse to that device's transfer engine, followed by a wait for a done pulse that carries a valid/invalid flag. A wait that runs past a fixed cycle budget counts as invalid. The first device that reports a valid image is selected, and no device after it is touched.

When all four storage devices fail, the sequencer switches the clock generator to its high-speed setting. It then alternates between the two host links (UART, then USB, then UART again) with no end, until one of them reports a valid image. A peripheral is un-idled only while it is being probed, and the selected one stays enabled. The low-voltage detector is held off from reset, which is the start of trim setup. A saturating counter of 1 ms ticks turns the detector back on after a set number of milliseconds, whatever phase the sequencer is in at that moment.

The clock multiplier values, the probe timeout, the trim length and the re-enable interval are parameters. The PLL, the transfer engines and image parsing sit outside the block.

Top module: `bootsrc_seq`

## Requirements
- R1: While reset is held: bootDone=0, bootSrc=7, probeStart=0, periphEnable=0 and lvdEnable=0, and the clock outputs show the slow mode. After reset is released, trimActive stays 1 for exactly TRIM_CYCLES cycles with no probe and no done. The first probe start comes in the cycle after that.
- R2: Source codes are 0 = SPI EEPROM with 16-bit address, 1 = SPI flash with 24-bit address, 2 = I2C EEPROM, 3 = SD card, 4 = UART host, 5 = USB host. Bit i of probeStart, probeDone, probeValid and periphEnable belongs to code i. Storage devices are probed in the order 0, 1, 2, 3, and each start is a one-cycle pulse.
- R3: When the device being probed reports done with valid=1, bootDone rises in the next cycle and bootSrc shows that device's code. No further probe is started, and bootDone and bootSrc hold until reset.
- R4: A probe fails if done arrives with valid=0, or if no done arrives within PROBE_TIMEOUT wait cycles. After a done with valid=0, the next start is in the cycle after the done is sampled. After a timeout, the next start comes PROBE_TIMEOUT+1 cycles after the previous start.
- R5: Slow mode: with clkSelExt=0, pllBypass=0 and pllMult=RTC_MULT_SLOW (375); with clkSelExt=1, pllBypass=1 and pllMult=1. Fast mode: with clkSelExt=0, pllMult=RTC_MULT_FAST (1125); with clkSelExt=1, pllMult=EXT_MULT_FAST (3); pllBypass=0 in both cases. Fast mode begins in the same cycle as the first UART start and lasts until reset.
- R6: After the SD probe fails, the host links are probed alternately (4, 5, 4, 5, ...) without limit until one reports a valid image.
- R7: periphEnable has at most one bit set. That bit belongs to the device whose start has been issued and whose answer is awaited. After selection, it belongs to the selected device.
- R8: A done or valid on any device other than the one being awaited, and any done during trim setup, has no effect on selection or on the probe sequence.
- R9: lvdEnable is 0 from reset. It becomes 1 in the cycle after the LVD_MS-th msTick sampled since reset release, during either storage or host probing. Once set, it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSelExt | input | 1 | Clock source select: 0 = RTC with PLL, 1 = external clock input (static) |
| msTick | input | 1 | One-cycle pulse every millisecond |
| probeDone | input | 6 | Per-source done pulse |
| probeValid | input | 6 | Per-source valid-image flag, read together with done |
| probeStart | output | 6 | Per-source one-cycle probe start |
| periphEnable | output | 6 | Per-source un-idle enable |
| trimActive | output | 1 | High during the trim-setup phase |
| pllBypass | output | 1 | PLL bypass request |
| pllMult | output | MULT_W | PLL multiplier request |
| lvdEnable | output | 1 | Low-voltage detector enable |
| bootDone | output | 1 | Source selected (stays set until reset) |
| bootSrc | output | 3 | Selected source code, 7 until selection |

## Verification
Results are due at fixed offsets from a stimulus:
- A done pulse on the awaited device shows up one cycle later, either as bootDone or as the next probe start.
- A silent device produces the next start exactly PROBE_TIMEOUT+1 cycles after the previous one.
- The first start follows reset release by TRIM_CYCLES cycles.
- lvdEnable rises one cycle after the LVD_MS-th tick.

The bench drives inputs and samples outputs on falling edges and counts those edges from each start. It then asserts equality at the exact cycle rather than waiting for an event. It sweeps both clock sources, every winning source, and several rounds of failed host polls, mixing timeouts, invalid answers and stray done pulses on other devices.

// File: rtl/bootsrc_pkg.sv
package bootsrc_pkg;

  // Source codes; the numeric order is the probe priority.
  localparam int NUM_SRC   = 6;
  localparam int SRC_W     = 3;
  localparam int LAST_STORE = 3;
  localparam int FIRST_HOST = 4;
  localparam int SECOND_HOST = 5;
  localparam logic [SRC_W-1:0] SRC_NONE = 3'd7;

  typedef enum logic [1:0] {
    ST_TRIM  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seqState_e;

  // Control -> datapath strobes.
  typedef struct packed {
    logic trimStep;   // trim phase in progress
    logic timerClr;   // restart the per-probe timeout
    logic timerStep;  // advance the per-probe timeout
    logic idxNext;    // move to the next source in priority order
    logic fastSet;    // switch the clock request to fast mode
    logic issueNow;   // pulse start to the current source
    logic holdEn;     // keep the current source un-idled
    logic doneNow;    // selection made
  } seqStrobe_t;

  // Datapath -> control status.
  typedef struct packed {
    logic trimLast;
    logic timeout;
    logic probeHit;
    logic probeOk;
    logic lastStore;
  } seqStatus_t;

endpackage

// File: rtl/bootsrc_ctrl.sv
module bootsrc_ctrl
  import bootsrc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStatus_t status,
  output seqStrobe_t strobe
);

  seqState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_TRIM;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_TRIM: begin
        strobe.trimStep = 1'b1;
        if (status.trimLast) stateD = ST_ISSUE;
      end
      ST_ISSUE: begin
        strobe.issueNow = 1'b1;
        strobe.holdEn   = 1'b1;
        strobe.timerClr = 1'b1;
        stateD          = ST_WAIT;
      end
      ST_WAIT: begin
        strobe.holdEn = 1'b1;
        if (status.probeHit && status.probeOk) begin
          stateD = ST_DONE;
        end else if (status.probeHit || status.timeout) begin
          strobe.idxNext = 1'b1;
          strobe.fastSet = status.lastStore;
          stateD         = ST_ISSUE;
        end else begin
          strobe.timerStep = 1'b1;
        end
      end
      ST_DONE: begin
        strobe.holdEn  = 1'b1;
        strobe.doneNow = 1'b1;
      end
      default: stateD = ST_TRIM;
    endcase
  end

endmodule

// File: rtl/bootsrc_dp.sv
module bootsrc_dp
  import bootsrc_pkg::*;
#(
  parameter int PROBE_TIMEOUT = 1024,
  parameter int TRIM_CYCLES   = 8,
  parameter int LVD_MS        = 200,
  parameter int MULT_W        = 11,
  parameter int RTC_MULT_SLOW = 375,
  parameter int RTC_MULT_FAST = 1125,
  parameter int EXT_MULT_FAST = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkSelExt,
  input  logic                 msTick,
  input  logic [NUM_SRC-1:0]   probeDone,
  input  logic [NUM_SRC-1:0]   probeValid,
  input  seqStrobe_t           strobe,
  output seqStatus_t           status,
  output logic [NUM_SRC-1:0]   probeStart,
  output logic [NUM_SRC-1:0]   periphEnable,
  output logic                 pllBypass,
  output logic [MULT_W-1:0]    pllMult,
  output logic                 lvdEnable,
  output logic [SRC_W-1:0]     bootSrc
);

  localparam int TMR_W  = $clog2(PROBE_TIMEOUT + 1);
  localparam int TRIM_W = $clog2(TRIM_CYCLES + 1);
  localparam int MS_W   = $clog2(LVD_MS + 1);

  logic [SRC_W-1:0]  idxQ, idxNxt;
  logic [TMR_W-1:0]  timerQ;
  logic [TRIM_W-1:0] trimQ;
  logic [MS_W-1:0]   msQ;
  logic              fastQ;
  logic [NUM_SRC-1:0] selVec;

  // One-hot decode of the current source.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
    assign selVec[g] = (idxQ == SRC_W'(g));
  end

  // Priority walk: storage in order, then the two hosts alternate.
  always_comb begin
    unique case (idxQ)
      SRC_W'(LAST_STORE):  idxNxt = SRC_W'(FIRST_HOST);
      SRC_W'(FIRST_HOST):  idxNxt = SRC_W'(SECOND_HOST);
      SRC_W'(SECOND_HOST): idxNxt = SRC_W'(FIRST_HOST);
      default:             idxNxt = idxQ + 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              idxQ <= '0;
    else if (strobe.idxNext) idxQ <= idxNxt;
  end

  // Per-probe timeout counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timerQ <= '0;
    else if (strobe.timerClr)  timerQ <= '0;
    else if (strobe.timerStep) timerQ <= timerQ + 1'b1;
  end

  // Trim-setup phase length.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                trimQ <= '0;
    else if (strobe.trimStep) trimQ <= trimQ + 1'b1;
  end

  // Millisecond counter since trim start, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 msQ <= '0;
    else if (msTick && (msQ != MS_W'(LVD_MS))) msQ <= msQ + 1'b1;
  end

  // Clock-mode request, sticky once set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               fastQ <= 1'b0;
    else if (strobe.fastSet) fastQ <= 1'b1;
  end

  always_comb begin
    status.trimLast  = (trimQ == TRIM_W'(TRIM_CYCLES - 1));
    status.timeout   = (timerQ == TMR_W'(PROBE_TIMEOUT - 1));
    status.probeHit  = |(probeDone & selVec);
    status.probeOk   = |(probeDone & probeValid & selVec);
    status.lastStore = (idxQ == SRC_W'(LAST_STORE));
  end

  assign probeStart   = strobe.issueNow ? selVec : '0;
  assign periphEnable = strobe.holdEn   ? selVec : '0;
  assign bootSrc      = strobe.doneNow  ? idxQ   : SRC_NONE;
  assign lvdEnable    = (msQ == MS_W'(LVD_MS));

  always_comb begin
    if (fastQ) begin
      pllBypass = 1'b0;
      pllMult   = clkSelExt ? MULT_W'(EXT_MULT_FAST) : MULT_W'(RTC_MULT_FAST);
    end else begin
      pllBypass = clkSelExt;
      pllMult   = clkSelExt ? MULT_W'(1) : MULT_W'(RTC_MULT_SLOW);
    end
  end

endmodule

// File: rtl/bootsrc_seq.sv
module bootsrc_seq
  import bootsrc_pkg::*;
#(
  parameter int PROBE_TIMEOUT = 1024,
  parameter int TRIM_CYCLES   = 8,
  parameter int LVD_MS        = 200,
  parameter int MULT_W        = 11,
  parameter int RTC_MULT_SLOW = 375,
  parameter int RTC_MULT_FAST = 1125,
  parameter int EXT_MULT_FAST = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkSelExt,
  input  logic              msTick,
  input  logic [5:0]        probeDone,
  input  logic [5:0]        probeValid,
  output logic [5:0]        probeStart,
  output logic [5:0]        periphEnable,
  output logic              trimActive,
  output logic              pllBypass,
  output logic [MULT_W-1:0] pllMult,
  output logic              lvdEnable,
  output logic              bootDone,
  output logic [2:0]        bootSrc
);

  seqStrobe_t strobe;
  seqStatus_t status;

  bootsrc_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe)
  );

  bootsrc_dp #(
    .PROBE_TIMEOUT (PROBE_TIMEOUT),
    .TRIM_CYCLES   (TRIM_CYCLES),
    .LVD_MS        (LVD_MS),
    .MULT_W        (MULT_W),
    .RTC_MULT_SLOW (RTC_MULT_SLOW),
    .RTC_MULT_FAST (RTC_MULT_FAST),
    .EXT_MULT_FAST (EXT_MULT_FAST)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .clkSelExt    (clkSelExt),
    .msTick       (msTick),
    .probeDone    (probeDone),
    .probeValid   (probeValid),
    .strobe       (strobe),
    .status       (status),
    .probeStart   (probeStart),
    .periphEnable (periphEnable),
    .pllBypass    (pllBypass),
    .pllMult      (pllMult),
    .lvdEnable    (lvdEnable),
    .bootSrc      (bootSrc)
  );

  assign trimActive = strobe.trimStep;
  assign bootDone   = strobe.doneNow;

endmodule

// File: rtl/bootsrc_chk.sv
module bootsrc_chk #(
  parameter int MULT_W        = 11,
  parameter int RTC_MULT_FAST = 1125,
  parameter int EXT_MULT_FAST = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkSelExt,
  input logic [5:0]        probeStart,
  input logic [5:0]        periphEnable,
  input logic              trimActive,
  input logic              pllBypass,
  input logic [MULT_W-1:0] pllMult,
  input logic              lvdEnable,
  input logic              bootDone,
  input logic [2:0]        bootSrc
);

  a_r1_trim_quiet: assert property (@(posedge clk) disable iff (!rstN)
    trimActive |-> (probeStart == 6'd0 && !bootDone));

  a_r2_start_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(probeStart));

  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (probeStart != 6'd0) |=> (probeStart == 6'd0));

  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |=> (bootDone && $stable(bootSrc)));

  a_r3_no_probe_after_done: assert property (@(posedge clk) disable iff (!rstN)
    bootDone |-> (probeStart == 6'd0 && bootSrc <= 3'd5));

  a_r5_host_fast: assert property (@(posedge clk) disable iff (!rstN)
    (periphEnable[5:4] != 2'b00) |->
      (!pllBypass && pllMult == (clkSelExt ? MULT_W'(EXT_MULT_FAST) : MULT_W'(RTC_MULT_FAST))));

  a_r7_enable_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(periphEnable));

  a_r7_start_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (probeStart != 6'd0) |-> (periphEnable == probeStart));

  a_r9_lvd_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lvdEnable |=> lvdEnable);

endmodule

bind bootsrc_seq bootsrc_chk #(
  .MULT_W        (MULT_W),
  .RTC_MULT_FAST (RTC_MULT_FAST),
  .EXT_MULT_FAST (EXT_MULT_FAST)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .clkSelExt    (clkSelExt),
  .probeStart   (probeStart),
  .periphEnable (periphEnable),
  .trimActive   (trimActive),
  .pllBypass    (pllBypass),
  .pllMult      (pllMult),
  .lvdEnable    (lvdEnable),
  .bootDone     (bootDone),
  .bootSrc      (bootSrc)
);

// File: tb/bootsrc_seq_tb.sv
module bootsrc_seq_tb;
  localparam int TO   = 16;
  localparam int TRIM = 4;
  localparam int LVD  = 200;
  localparam int MW   = 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic          clkSelExt = 1'b0;
  logic          msTick = 1'b0;
  logic [5:0]    probeDone = '0;
  logic [5:0]    probeValid = '0;
  logic [5:0]    probeStart, periphEnable;
  logic          trimActive, pllBypass, lvdEnable, bootDone;
  logic [MW-1:0] pllMult;
  logic [2:0]    bootSrc;

  int checks = 0;
  int failures = 0;

  bootsrc_seq #(
    .PROBE_TIMEOUT (TO),
    .TRIM_CYCLES   (TRIM),
    .LVD_MS        (LVD),
    .MULT_W        (MW)
  ) u_dut (
    .clk(clk), .rstN(rstN), .clkSelExt(clkSelExt), .msTick(msTick),
    .probeDone(probeDone), .probeValid(probeValid), .probeStart(probeStart),
    .periphEnable(periphEnable), .trimActive(trimActive), .pllBypass(pllBypass),
    .pllMult(pllMult), .lvdEnable(lvdEnable), .bootDone(bootDone), .bootSrc(bootSrc)
  );

  task automatic chkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expMult(bit sel, bit fast);
    if (fast) return sel ? 3 : 1125;
    return sel ? 1 : 375;
  endfunction

  task automatic doReset(bit sel);
    @(negedge clk);
    rstN = 1'b0; clkSelExt = sel; probeDone = '0; probeValid = '0;
    repeat (2) @(negedge clk);
    chkEq("R1", "bootDone in reset", int'(bootDone), 0);
    chkEq("R1", "bootSrc in reset", int'(bootSrc), 7);
    chkEq("R1", "probeStart in reset", int'(probeStart), 0);
    chkEq("R1", "periphEnable in reset", int'(periphEnable), 0);
    chkEq("R1", "lvdEnable in reset", int'(lvdEnable), 0);
    chkEq("R5", "pllMult slow", int'(pllMult), expMult(sel, 1'b0));
    chkEq("R5", "pllBypass slow", int'(pllBypass), int'(sel));
    rstN = 1'b1;
    probeDone = 6'h3f; probeValid = 6'h3f;   // R8: noise during trim
    chkEq("R1", "trimActive at release", int'(trimActive), 1);
    for (int k = 1; k < TRIM; k++) begin
      @(negedge clk);
      chkEq("R1", "trimActive", int'(trimActive), 1);
      chkEq("R8", "no start during trim", int'(probeStart), 0);
      chkEq("R8", "no done during trim", int'(bootDone), 0);
    end
    probeDone = '0; probeValid = '0;
  endtask

  task automatic waitStart(bit advance, output int gap);
    gap = 0;
    if (advance) begin @(negedge clk); gap = 1; end
    while (probeStart == 6'd0 && gap < 200) begin @(negedge clk); gap++; end
  endtask

  task automatic probeAt(bit sel, int idx, bit advance, int expGap, string gapReq);
    int gap;
    waitStart(advance, gap);
    chkEq(gapReq, "start cycle offset", gap, expGap);
    chkEq(idx >= 4 ? "R6" : "R2", "start vector", int'(probeStart), 1 << idx);
    chkEq("R7", "enable vector at start", int'(periphEnable), 1 << idx);
    chkEq("R5", "pllMult", int'(pllMult), expMult(sel, idx >= 4));
    chkEq("R5", "pllBypass", int'(pllBypass), int'(sel && idx < 4));
  endtask

  task automatic answer(int idx, int d, bit valid, bit noise);
    for (int c = 1; c <= d; c++) begin
      @(negedge clk);
      chkEq("R2", "start is a pulse", int'(probeStart), 0);
      chkEq("R8", "no selection while waiting", int'(bootDone), 0);
      chkEq("R7", "enable while waiting", int'(periphEnable), 1 << idx);
      probeDone = '0; probeValid = '0;
      if (noise && c == 1) begin
        probeDone = 6'(1 << ((idx + 1) % 6)); probeValid = 6'h3f;
      end
      if (c == d) begin
        probeDone = 6'(1 << idx); probeValid = valid ? 6'(1 << idx) : 6'h0;
      end
    end
    @(negedge clk);
    probeDone = '0; probeValid = '0;
    if (valid) begin
      chkEq("R3", "bootDone after valid", int'(bootDone), 1);
      chkEq("R3", "bootSrc after valid", int'(bootSrc), idx);
      chkEq("R7", "selected stays enabled", int'(periphEnable), 1 << idx);
    end
  endtask

  task automatic runCase(bit sel, int winner, int rounds);
    int seqList[$];
    int mode;
    doReset(sel);
    for (int i = 0; i <= 3 && i <= winner; i++) seqList.push_back(i);
    if (winner >= 4)
      for (int h = 0; h < 2 * rounds + (winner - 4) + 1; h++) seqList.push_back(4 + (h % 2));
    mode = 0;
    foreach (seqList[p]) begin
      int idx = seqList[p];
      if (mode == 0)      probeAt(sel, idx, 1'b1, 1, "R1");
      else if (mode == 1) probeAt(sel, idx, 1'b1, TO + 1, "R4");
      else                probeAt(sel, idx, 1'b0, 0, "R4");
      if (p == seqList.size() - 1) begin
        int extra = 0;
        answer(idx, 1 + (p % 3), 1'b1, (p % 3) == 2);
        for (int c = 0; c < 25; c++) begin
          @(negedge clk);
          if (probeStart != 6'd0) extra++;
        end
        chkEq("R3", "no probe after selection", extra, 0);
        chkEq("R3", "bootDone held", int'(bootDone), 1);
        chkEq("R3", "bootSrc held", int'(bootSrc), idx);
        chkEq("R9", "lvd off without ticks", int'(lvdEnable), 0);
      end else if (((p + sel + winner) % 3) == 0) begin
        mode = 1;   // silent device: timeout
      end else begin
        int d = 1 + (p % 4);
        answer(idx, d, 1'b0, d >= 3);
        mode = 2;
      end
    end
  endtask

  task automatic lvdCase();
    int starts = 0;
    @(negedge clk);
    rstN = 1'b0; clkSelExt = 1'b0; msTick = 1'b1; probeDone = '0; probeValid = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int k = 1; k <= 420; k++) begin
      @(negedge clk);
      if (k > LVD && probeStart != 6'd0) starts++;
      if (k == TRIM - 1) chkEq("R9", "lvd off in trim", int'(lvdEnable), 0);
      if (k == LVD - 1)  chkEq("R9", "lvd before last tick", int'(lvdEnable), 0);
      if (k == LVD) begin
        chkEq("R9", "lvd after last tick", int'(lvdEnable), 1);
        chkEq("R9", "host polling under way", int'(periphEnable[5:4] != 2'b00), 1);
      end
    end
    chkEq("R9", "lvd stays on", int'(lvdEnable), 1);
    chkEq("R6", "polling continues", int'(starts > 10), 1);
    chkEq("R6", "still no selection", int'(bootDone), 0);
    msTick = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 6; w++)
        if (w < 4) runCase(s[0], w, 0);
        else for (int r = 0; r < 3; r++) runCase(s[0], w, r);
    lvdCase();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule